// File: doc/BRIEF.md
# Start-Gated Strobe Decimator

The block watches a repetitive external strobe and counts its pulses. It counts only after a start request has armed it. When the programmed number of strobes has arrived, it raises a single-cycle done pulse that can trigger a downstream block, and then drops back to idle until the next start. A new start is needed for every count.

The strobe is asynchronous to the system clock and lasts several clock cycles. It is resampled by a two-flop synchronizer and then passed through a rising-edge detector, so each strobe advances the count exactly once. The strobe is never used as a clock. The decimation ratio is a 16-bit value. A ratio of zero behaves the same as a ratio of one. The external active-low reset asserts asynchronously and is released through a small synchronizer inside the block.

Top module: `strobe_decimator`

## Requirements
- R1: While reset is asserted and after it is released, `done_o` is low and the block is idle.
- R2: In idle, strobes are not counted and never produce `done_o`.
- R3: After a start, `done_o` pulses exactly when the N-th strobe has been counted, where N is the unsigned 16-bit `ratio_i` (ratios above 255 included).
- R4: `done_o` is high for exactly one cycle, and the block then returns to idle, so later strobes without a new start produce no pulse.
- R5: A strobe held high for 2, 3 or 4 clock cycles counts as one event.
- R6: A `ratio_i` of 0 is treated as 1: the first strobe after start completes the count.
- R7: A start asserted while counting has no effect: the count is neither restarted nor extended.
- R8: If the final strobe is first high at clock edge k, `done_o` is high from edge k+2 to edge k+3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Arms the counter when the block is idle |
| strobe_i | input | 1 | Asynchronous repetitive strobe to be counted |
| ratio_i | input | 16 | Number of strobes per done pulse (0 counts as 1); hold stable while counting |
| done_o | output | 1 | Single-cycle pulse once the count completes |

## Verification
The assertions check four things on every cycle. The synchronizer emits one-cycle events, and only for a strobe seen high the synchronizer depth earlier. The done pulse is always single, and it always follows a counted event in the counting state. While counting, the index stays within the ratio and does not change without an event, which is what makes start have no effect. Only the bench scenarios can show the counts that depend on the stimulus: the exact cycle at which done fires for several ratios (including zero and a ratio above 255), strobes of varying width, strobes sent in idle or after completion, and start requests repeated in the middle of a count.

// File: rtl/pdec_pkg.sv
package pdec_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_COUNT = 1'b1
  } pdec_state_e;
endpackage

// File: rtl/pdec_rst_sync.sv
// Reset synchronizer: asserts asynchronously, releases on the clock.
module pdec_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/pdec_strobe_sync.sv
// Resamples the strobe and turns each rising edge into a one-cycle event.
module pdec_strobe_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  output logic event_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], strobe_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign event_o = sync_q[SYNC_STAGES-1] & ~prev_q;

  // R5: an event never lasts more than one cycle
  assert_event_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |=> !event_o);

  // R5: an event traces back to a strobe seen high SYNC_STAGES edges earlier
  assert_event_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |-> $past(strobe_i, SYNC_STAGES));
endmodule

// File: rtl/pdec_ctrl.sv
// Idle/counting controller with the strobe index and the done pulse.
module pdec_ctrl
  import pdec_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             event_i,
  input  logic [CNT_W-1:0] ratio_i,
  output logic             done_o
);
  pdec_state_e      state_q, state_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] last_idx;
  logic             idx_en;
  logic             done_d;

  // ratio 0 behaves as ratio 1
  assign last_idx = (ratio_i == '0) ? '0 : ratio_i - 1'b1;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        idx_d = '0;
        if (start_i) state_d = ST_COUNT;
      end
      ST_COUNT: begin
        if (event_i) begin
          if (idx_q == last_idx) begin
            done_d  = 1'b1;
            idx_d   = '0;
            state_d = ST_IDLE;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign idx_en = (state_q == ST_IDLE) || event_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= done_d;
      if (idx_en) idx_q <= idx_d;
    end
  end

  // R4: done is a single-cycle pulse
  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R3: done only follows a counted event while counting
  assert_done_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(state_q == ST_COUNT && event_i));

  // R3: the index stays inside the programmed ratio
  assert_index_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COUNT) |-> (idx_q <= last_idx));

  // R7: without an event, counting continues unchanged whatever start does
  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COUNT && !event_i) |=> (state_q == ST_COUNT && $stable(idx_q)));

  // R2: idle never produces done
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |=> !done_o);
endmodule

// File: rtl/strobe_decimator.sv
module strobe_decimator #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             strobe_i,
  input  logic [CNT_W-1:0] ratio_i,
  output logic             done_o
);
  logic rst_n_int;
  logic strobe_evt;

  pdec_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_int)
  );

  pdec_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .strobe_i (strobe_i),
    .event_o  (strobe_evt)
  );

  pdec_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .start_i (start_i),
    .event_i (strobe_evt),
    .ratio_i (ratio_i),
    .done_o  (done_o)
  );
endmodule

// File: tb/test_strobe_decimator.sv
module test_strobe_decimator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        strobe_i = 1'b0;
  logic [15:0] ratio_i = 16'd0;
  logic        done_o;

  int unsigned cyc = 0;
  int          checks = 0;
  int          fails = 0;
  bit          finished = 1'b0;

  typedef struct {
    int unsigned cyc;
    string       req;
  } exp_t;
  exp_t exp_q[$];
  exp_t got;

  strobe_decimator i_strobe_decimator (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .strobe_i (strobe_i),
    .ratio_i  (ratio_i),
    .done_o   (done_o)
  );

  always #4 clk = ~clk;  // 125 MHz

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: every done pulse must match the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R2 or R4: unexpected done at cycle %0d (actual 1, expected 0)", cyc);
      end else begin
        got = exp_q.pop_front();
        if (got.cyc != cyc) begin
          fails++;
          $display("FAIL %s/R8: done at cycle %0d, expected cycle %0d", got.req, cyc, got.cyc);
        end
      end
    end
  end

  task automatic arm();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  // One strobe of the given width; if req is set, this strobe should end the count (R8)
  task automatic pulse(int width, int gap, string req);
    @(negedge clk);
    strobe_i = 1'b1;
    if (req != "") exp_q.push_back('{cyc + 3, req});
    repeat (width) @(negedge clk);
    strobe_i = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic close_case(string req);
    repeat (8) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL %s: %0d expected done pulses missing (actual 0, expected %0d)",
               req, exp_q.size(), exp_q.size());
      exp_q.delete();
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;  // R1 during reset
    if (done_o !== 1'b0) begin
      fails++;
      $display("FAIL R1: done during reset actual %b expected 0", done_o);
    end
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    checks++;  // R1 after release
    if (done_o !== 1'b0) begin
      fails++;
      $display("FAIL R1: done after reset actual %b expected 0", done_o);
    end

    // R2: strobes in idle are not counted
    ratio_i = 16'd1;
    pulse(3, 4, "");
    pulse(2, 4, "");
    close_case("R2");

    // R3, R5: ratio 3 with widths 2, 3 and 4
    ratio_i = 16'd3;
    arm();
    pulse(2, 5, "");
    pulse(3, 5, "");
    pulse(4, 5, "R3");
    close_case("R3");

    // R4: back in idle, more strobes give nothing
    pulse(3, 5, "");
    pulse(2, 5, "");
    close_case("R4");

    // R5: the widest strobe counts once with ratio 2
    ratio_i = 16'd2;
    arm();
    pulse(4, 6, "");
    pulse(4, 6, "R5");
    close_case("R5");

    // R3: ratio 1
    ratio_i = 16'd1;
    arm();
    pulse(2, 5, "R3");
    close_case("R3");

    // R6: ratio 0 acts as 1
    ratio_i = 16'd0;
    arm();
    pulse(3, 5, "R6");
    close_case("R6");

    // R7: start repeated in the middle of a count of 5
    ratio_i = 16'd5;
    arm();
    pulse(2, 4, "");
    pulse(3, 4, "");
    arm();
    pulse(2, 4, "");
    arm();
    pulse(2, 4, "");
    pulse(2, 4, "R7");
    close_case("R7");

    // R3: ratio wider than 8 bits
    ratio_i = 16'd1000;
    arm();
    for (int i = 0; i < 999; i++) pulse(2, 3, "");
    pulse(2, 3, "R3");
    close_case("R3");

    // R4: a fresh start after completion works again
    ratio_i = 16'd2;
    arm();
    pulse(3, 4, "");
    pulse(2, 4, "R4");
    close_case("R4");

    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    report();
  end
endmodule